// File: doc/BRIEF.md
# Interrupt-Paced Queue Accumulator

This block watches one descriptor queue, or a window of contiguous queues, held by an external queue manager. Whenever a watched queue reports that it holds descriptors, the block requests a pop from that queue. Each non-null descriptor address it receives is stored in the next free slot of a host list memory. The block tracks how many slots are filled and raises an interrupt toward the host when the list reaches its programmed size, or when a delay measured under the selected pacing policy has run out.

The delay is programmed in microseconds. A prescaler parameter gives the number of clock cycles per microsecond. When the host acknowledges the interrupt, the list is emptied and the pacing reference restarts. The queue window is set by a base queue number and a single/multi select. The list size, pacing policy and latency are static inputs that change only while the block is held in reset.

Top module: `qacc_top`

## Requirements
- R1: After reset, irq is 0, listCount is 0, popReq is 0 and listWrEn is 0.
- R2: With cfgMulti=0, only the base queue is popped (popQueue equals cfgBaseQueue), and non-empty flags on the other offsets have no effect.
- R3: With cfgMulti=1, offsets 0..WATCH-1 above cfgBaseQueue are visited round-robin, starting at offset 0 after reset. At most one descriptor is popped per visit, and popQueue equals cfgBaseQueue plus the offset.
- R4: A popped descriptor that is non-zero is written at list index listCount, and listCount then increments. A zero descriptor is discarded: nothing is written and the count is unchanged.
- R5: irq rises at the same clock edge at which listCount reaches cfgListSize. No pop is requested while listCount equals cfgListSize.
- R6: With pace code 0, no interrupt is raised until the list is full.
- R7: With pace code 1, the delay reference is the last acknowledge (or reset). irq is set at the (L*P+1)-th rising edge after the reference edge, where L is cfgLatencyUs and P is cycles per microsecond.
- R8: With pace code 2, the reference is the write of the first descriptor since the last acknowledge or reset, and the same L*P+1 edge timing applies.
- R9: With pace code 3, the reference is the write of the most recent descriptor, and the same edge timing applies.
- R10: An irqAck sampled while irq is 1 clears irq and sets listCount to 0. An irqAck sampled while irq is 0 changes neither.
- R11: If a descriptor write falls in the same cycle as an effective acknowledge, the write goes to index 0 and listCount becomes 1.
- R12: A timed interrupt is raised only when the list holds at least one entry. An expired delay with an empty list waits for the next write, and irq then rises one edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBaseQueue | input | QID_W | First queue number of the watched window |
| cfgMulti | input | 1 | 1: watch WATCH queues; 0: watch the base queue only |
| cfgListSize | input | CNT_W | List capacity in entries (1..MAX_ENTRIES) |
| cfgPaceMode | input | 2 | Pacing code 0..3 |
| cfgLatencyUs | input | LAT_W | Interrupt delay in microseconds |
| qNotEmpty | input | WATCH | Bit i set when queue base+i holds descriptors |
| popReq | output | 1 | Pop request, held until popDone |
| popQueue | output | QID_W | Queue number to pop |
| popDone | input | 1 | Pop response valid |
| popDesc | input | DESC_W | Popped descriptor address, 0 for none |
| listWrEn | output | 1 | List memory write strobe |
| listWrAddr | output | ADDR_W | List memory write index |
| listWrData | output | DESC_W | Descriptor address to store |
| listCount | output | CNT_W | Number of filled list entries |
| irq | output | 1 | Interrupt to host, level |
| irqAck | input | 1 | Host acknowledge |

## Verification
The acknowledge from the host and the landing of a popped descriptor can occur in the same cycle. Both act on the list count: one clears it, the other advances it. The bench provokes this by raising a timed interrupt with one entry, queueing a second descriptor, and asserting irqAck at the very cycle the write strobe is seen. It then judges that the write index is 0, that the count settles at 1 with irq cleared, and that the list slot 0 holds the new descriptor.

// File: rtl/qacc_pkg.sv
package qacc_pkg;

  typedef enum logic [1:0] {
    PACE_FULL_ONLY   = 2'd0,
    PACE_SINCE_IRQ   = 2'd1,
    PACE_SINCE_FIRST = 2'd2,
    PACE_SINCE_LAST  = 2'd3
  } pace_e;

  typedef struct packed {
    logic wrStb;    // store the returned descriptor
    logic clrList;  // effective host acknowledge
    logic advPtr;   // move the scan pointer on
  } accStrobes_t;

endpackage

// File: rtl/qacc_pacer.sv
module qacc_pacer
  import qacc_pkg::*;
#(
  parameter int LAT_W        = 10,
  parameter int CNT_W        = 5,
  parameter int TICKS_PER_US = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgPaceMode,
  input  logic [LAT_W-1:0] cfgLatencyUs,
  input  accStrobes_t      strobes,
  input  logic [CNT_W-1:0] countIn,
  output logic             expired
);

  localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

  logic [PRE_W-1:0] preCnt;
  logic [LAT_W-1:0] usCnt;
  logic             restart;
  logic             armed;
  logic             tick;
  pace_e            mode;

  assign mode = pace_e'(cfgPaceMode);
  assign tick = (preCnt == PRE_W'(TICKS_PER_US - 1));

  always_comb begin
    restart = 1'b0;
    armed   = 1'b0;
    case (mode)
      PACE_SINCE_IRQ: begin
        restart = strobes.clrList;
        armed   = 1'b1;
      end
      PACE_SINCE_FIRST: begin
        restart = strobes.wrStb && (strobes.clrList || countIn == '0);
        armed   = (countIn != '0);
      end
      PACE_SINCE_LAST: begin
        restart = strobes.wrStb;
        armed   = (countIn != '0);
      end
      default: begin
        restart = 1'b0;
        armed   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      preCnt <= '0;
      usCnt  <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + PRE_W'(1);
      if (tick && usCnt != '1) usCnt <= usCnt + LAT_W'(1);
    end
  end

  assign expired = armed && (usCnt >= cfgLatencyUs);

  // R8
  first_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPaceMode == 2'd2 && $past(strobes.wrStb) && $past(countIn) == '0) |-> usCnt == '0);

endmodule

// File: rtl/qacc_dp.sv
module qacc_dp
  import qacc_pkg::*;
#(
  parameter int QID_W  = 14,
  parameter int DESC_W = 32,
  parameter int WATCH  = 32,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 4,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [QID_W-1:0]  cfgBaseQueue,
  input  logic              cfgMulti,
  input  logic [CNT_W-1:0]  cfgListSize,
  input  logic [WATCH-1:0]  qNotEmpty,
  input  logic [DESC_W-1:0] popDesc,
  input  accStrobes_t       strobes,
  output logic              curFlag,
  output logic [QID_W-1:0]  popQueue,
  output logic              listWrEn,
  output logic [ADDR_W-1:0] listWrAddr,
  output logic [DESC_W-1:0] listWrData,
  output logic [CNT_W-1:0]  countOut
);

  logic [CNT_W-1:0] fillCnt;
  logic [PTR_W-1:0] scanPtr;
  logic             ptrWrap;

  assign ptrWrap = (scanPtr == PTR_W'(WATCH - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !cfgMulti) scanPtr <= '0;
    else if (strobes.advPtr) scanPtr <= ptrWrap ? '0 : scanPtr + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) fillCnt <= '0;
    else if (strobes.clrList) fillCnt <= strobes.wrStb ? CNT_W'(1) : '0;
    else if (strobes.wrStb) fillCnt <= fillCnt + CNT_W'(1);
  end

  assign curFlag    = qNotEmpty[scanPtr];
  assign popQueue   = cfgBaseQueue + QID_W'(scanPtr);
  assign listWrEn   = strobes.wrStb;
  assign listWrAddr = strobes.clrList ? '0 : fillCnt[ADDR_W-1:0];
  assign listWrData = popDesc;
  assign countOut   = fillCnt;

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= cfgListSize);

  // R10 R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.clrList) |-> fillCnt == ($past(strobes.wrStb) ? CNT_W'(1) : CNT_W'(0)));

  // R2
  single_queue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMulti && $past(!cfgMulti)) |-> popQueue == cfgBaseQueue);

endmodule

// File: rtl/qacc_ctrl.sv
module qacc_ctrl
  import qacc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMulti,
  input  logic [CNT_W-1:0] cfgListSize,
  input  logic [1:0]       cfgPaceMode,
  input  logic             curFlag,
  input  logic [CNT_W-1:0] countIn,
  input  logic             popDone,
  input  logic             descNonNull,
  input  logic             irqAck,
  input  logic             expired,
  output accStrobes_t      strobes,
  output logic             popReq,
  output logic             irq
);

  typedef enum logic {ST_SCAN, ST_WAIT} st_e;

  st_e              st, stNext;
  logic             irqQ;
  logic             isFull;
  logic             fillHit;
  logic             timedFire;
  logic [CNT_W-1:0] fillLevel;

  assign isFull = (countIn >= cfgListSize);

  always_comb begin
    stNext  = st;
    strobes = '0;
    case (st)
      ST_SCAN: begin
        if (curFlag && !isFull) stNext = ST_WAIT;
        else strobes.advPtr = cfgMulti;
      end
      ST_WAIT: begin
        if (popDone) begin
          strobes.wrStb  = descNonNull;
          strobes.advPtr = cfgMulti;
          stNext         = ST_SCAN;
        end
      end
      default: stNext = ST_SCAN;
    endcase
    strobes.clrList = irqAck && irqQ;
  end

  assign fillLevel = strobes.clrList ? CNT_W'(1) : countIn + CNT_W'(1);
  assign fillHit   = strobes.wrStb && (fillLevel == cfgListSize);
  assign timedFire = !irqQ && expired && (countIn != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_SCAN;
      irqQ <= 1'b0;
    end else begin
      st <= stNext;
      if (fillHit || timedFire) irqQ <= 1'b1;
      else if (strobes.clrList) irqQ <= 1'b0;
    end
  end

  assign popReq = (st == ST_WAIT);
  assign irq    = irqQ;

  // R5
  no_pop_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WAIT && $past(st) == ST_SCAN) |-> $past(countIn) < $past(cfgListSize));

  // R12
  irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> countIn != '0);

  // R6
  full_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqQ) && cfgPaceMode == 2'd0) |-> countIn == cfgListSize);

endmodule

// File: rtl/qacc_top.sv
module qacc_top
  import qacc_pkg::*;
#(
  parameter int QID_W        = 14,
  parameter int DESC_W       = 32,
  parameter int WATCH        = 32,
  parameter int MAX_ENTRIES  = 16,
  parameter int LAT_W        = 10,
  parameter int TICKS_PER_US = 250,
  localparam int CNT_W       = $clog2(MAX_ENTRIES + 1),
  localparam int ADDR_W      = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int PTR_W       = (WATCH > 1) ? $clog2(WATCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [QID_W-1:0]  cfgBaseQueue,
  input  logic              cfgMulti,
  input  logic [CNT_W-1:0]  cfgListSize,
  input  logic [1:0]        cfgPaceMode,
  input  logic [LAT_W-1:0]  cfgLatencyUs,
  input  logic [WATCH-1:0]  qNotEmpty,
  output logic              popReq,
  output logic [QID_W-1:0]  popQueue,
  input  logic              popDone,
  input  logic [DESC_W-1:0] popDesc,
  output logic              listWrEn,
  output logic [ADDR_W-1:0] listWrAddr,
  output logic [DESC_W-1:0] listWrData,
  output logic [CNT_W-1:0]  listCount,
  output logic              irq,
  input  logic              irqAck
);

  accStrobes_t      strobes;
  logic             curFlag;
  logic             expired;
  logic [CNT_W-1:0] countW;

  qacc_ctrl #(.CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .cfgMulti(cfgMulti), .cfgListSize(cfgListSize),
    .cfgPaceMode(cfgPaceMode), .curFlag(curFlag), .countIn(countW),
    .popDone(popDone), .descNonNull(popDesc != '0), .irqAck(irqAck),
    .expired(expired), .strobes(strobes), .popReq(popReq), .irq(irq)
  );

  qacc_dp #(
    .QID_W(QID_W), .DESC_W(DESC_W), .WATCH(WATCH),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
  ) dp (
    .clk(clk), .rstN(rstN), .cfgBaseQueue(cfgBaseQueue), .cfgMulti(cfgMulti),
    .cfgListSize(cfgListSize), .qNotEmpty(qNotEmpty), .popDesc(popDesc),
    .strobes(strobes), .curFlag(curFlag), .popQueue(popQueue),
    .listWrEn(listWrEn), .listWrAddr(listWrAddr), .listWrData(listWrData),
    .countOut(countW)
  );

  qacc_pacer #(.LAT_W(LAT_W), .CNT_W(CNT_W), .TICKS_PER_US(TICKS_PER_US)) pacer (
    .clk(clk), .rstN(rstN), .cfgPaceMode(cfgPaceMode), .cfgLatencyUs(cfgLatencyUs),
    .strobes(strobes), .countIn(countW), .expired(expired)
  );

  assign listCount = countW;

endmodule

// File: tb/qacc_top_test.sv
`timescale 1ns/1ps
module qacc_top_test;

  localparam int TPU   = 4;
  localparam int BASE  = 100;
  localparam int NQ    = 32;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] cfgBaseQueue = 14'(BASE);
  logic        cfgMulti = 1'b0;
  logic [4:0]  cfgListSize = 5'd16;
  logic [1:0]  cfgPaceMode = 2'd0;
  logic [9:0]  cfgLatencyUs = 10'd0;
  logic [31:0] qNotEmpty;
  logic        popReq;
  logic [13:0] popQueue;
  logic        popDone = 1'b0;
  logic [31:0] popDesc = '0;
  logic        listWrEn;
  logic [3:0]  listWrAddr;
  logic [31:0] listWrData;
  logic [4:0]  listCount;
  logic        irq;
  logic        irqAck = 1'b0;

  int total = 0;
  int bad = 0;
  int qLen [NQ];
  int qHead [NQ];
  logic [31:0] qData [NQ][DEPTH];
  logic [31:0] listMem [16];

  qacc_top #(.TICKS_PER_US(TPU)) uut (
    .clk(clk), .rstN(rstN), .cfgBaseQueue(cfgBaseQueue), .cfgMulti(cfgMulti),
    .cfgListSize(cfgListSize), .cfgPaceMode(cfgPaceMode), .cfgLatencyUs(cfgLatencyUs),
    .qNotEmpty(qNotEmpty), .popReq(popReq), .popQueue(popQueue), .popDone(popDone),
    .popDesc(popDesc), .listWrEn(listWrEn), .listWrAddr(listWrAddr),
    .listWrData(listWrData), .listCount(listCount), .irq(irq), .irqAck(irqAck)
  );

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < NQ; i++) qNotEmpty[i] = (qLen[i] != 0);

  always @(posedge clk) if (listWrEn) listMem[listWrAddr] <= listWrData;

  // queue manager model: answers a pop 2 ns after the edge that raised it
  always @(posedge clk) begin
    #2;
    if (popReq && !popDone) begin
      int off;
      off = int'(popQueue) - BASE;
      if (off < 0 || off >= NQ) begin
        total++; bad++;
        $display("FAIL R3 popQueue actual=%0d expected=%0d..%0d", popQueue, BASE, BASE + NQ - 1);
        popDesc = '0;
      end else if (qLen[off] == 0) begin
        popDesc = '0;
      end else begin
        popDesc = qData[off][qHead[off]];
        qHead[off]++;
        qLen[off]--;
      end
      popDone = 1'b1;
    end else begin
      popDone = 1'b0;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int off, input logic [31:0] val);
    qData[off][qHead[off] + qLen[off]] = val;
    qLen[off]++;
  endtask

  task automatic doReset(input logic multi, input int size, input int mode, input int lat);
    @(negedge clk);
    rstN = 1'b0;
    cfgMulti = multi;
    cfgListSize = 5'(size);
    cfgPaceMode = 2'(mode);
    cfgLatencyUs = 10'(lat);
    irqAck = 1'b0;
    for (int i = 0; i < NQ; i++) begin qLen[i] = 0; qHead[i] = 0; end
    for (int i = 0; i < 16; i++) listMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitWrite();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!listWrEn && n < 200);
  endtask

  task automatic countToIrq(output int n);
    n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int lc [NQ];
    int expN;
    logic [31:0] expList [16];

    // R1 reset state
    doReset(1'b0, 16, 0, 0);
    #1;
    chk("R1 irq", irq, 0);
    chk("R1 listCount", listCount, 0);
    chk("R1 popReq", popReq, 0);
    chk("R1 listWrEn", listWrEn, 0);

    // R2 R4 R6: single queue, null descriptor dropped, other queue ignored
    push(0, 32'd11); push(0, 32'd0); push(0, 32'd13); push(3, 32'd99);
    idle(40);
    chk("R4 count after null", listCount, 2);
    chk("R4 entry0", listMem[0], 11);
    chk("R4 entry1", listMem[1], 13);
    chk("R2 offset3 untouched", qLen[3], 1);
    chk("R6 no timed irq", irq, 0);

    // R5 full trigger and pause, R10 acknowledge
    doReset(1'b0, 4, 0, 0);
    for (int i = 0; i < 5; i++) push(0, 32'(200 + i));
    n = 0;
    while (listCount != 5'd4 && n < 60) begin @(negedge clk); n++; end
    chk("R5 count full", listCount, 4);
    chk("R5 irq with full", irq, 1);
    idle(30);
    chk("R5 still full", listCount, 4);
    chk("R5 fifth pending", qLen[0], 1);
    chk("R5 no popReq", popReq, 0);
    for (int i = 0; i < 4; i++) chk("R5 list order", listMem[i], 200 + i);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    chk("R10 count cleared", listCount, 0);
    chk("R10 irq cleared", irq, 0);
    idle(10);
    chk("R10 refill count", listCount, 1);
    chk("R10 refill entry", listMem[0], 204);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    idle(2);
    chk("R10 ignored ack count", listCount, 1);
    chk("R10 ignored ack irq", irq, 0);

    // R3 round robin over the window
    doReset(1'b1, 16, 0, 0);
    for (int i = 0; i < NQ; i++) lc[i] = 0;
    lc[0] = 2; lc[1] = 2; lc[2] = 2; lc[3] = 2; lc[31] = 1; lc[17] = 3;
    for (int q = 0; q < NQ; q++)
      for (int k = 0; k < lc[q]; k++) push(q, 32'(q * 16 + k + 1));
    expN = 0;
    for (int r = 0; r < 3; r++)
      for (int q = 0; q < NQ; q++)
        if (r < lc[q]) begin expList[expN] = 32'(q * 16 + r + 1); expN++; end
    idle(200);
    chk("R3 total entries", listCount, expN);
    for (int i = 0; i < expN; i++) chk("R3 order", listMem[i], expList[i]);

    // R8 pace code 2, latency sweep
    for (int lat = 0; lat < 4; lat++) begin
      doReset(1'b0, 16, 2, lat);
      idle(20);
      chk("R8 quiet before data", irq, 0);
      push(0, 32'h50 + 32'(lat));
      waitWrite();
      countToIrq(n);
      chk("R8 delay", n, lat * TPU + 2);
    end

    // R9 pace code 3, reference is last write
    for (int lat = 1; lat < 4; lat++) begin
      doReset(1'b0, 16, 3, lat);
      push(0, 32'h60);
      waitWrite();
      idle(1);
      push(0, 32'h61);
      waitWrite();
      chk("R9 no early irq", irq, 0);
      countToIrq(n);
      chk("R9 delay", n, lat * TPU + 2);
    end

    // R7 pace code 1, reference is acknowledge
    for (int lat = 1; lat < 4; lat++) begin
      doReset(1'b0, 16, 1, lat);
      push(0, 32'h70);
      countToIrq(n);
      chk("R7 first irq", irq, 1);
      irqAck = 1'b1;
      push(0, 32'h71);
      n = 0;
      do begin @(negedge clk); n++; irqAck = 1'b0; end while (!irq && n < 400);
      chk("R7 delay", n, lat * TPU + 2);
    end

    // R12 expired with empty list waits for data
    doReset(1'b0, 16, 1, 1);
    idle(30);
    chk("R12 empty no irq", irq, 0);
    push(0, 32'h80);
    waitWrite();
    countToIrq(n);
    chk("R12 fire after write", n, 2);

    // R11 acknowledge and write in the same cycle
    doReset(1'b0, 4, 1, 1);
    push(0, 32'h90);
    countToIrq(n);
    chk("R11 setup irq", irq, 1);
    push(0, 32'h91);
    waitWrite();
    irqAck = 1'b1;
    #1;
    chk("R11 write index", listWrAddr, 0);
    @(negedge clk);
    irqAck = 1'b0;
    chk("R11 count", listCount, 1);
    chk("R11 irq cleared", irq, 0);
    chk("R11 entry0", listMem[0], 32'h91);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule